// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a synthesizable, clocked model of a pipelined synchronous static RAM that deselects in a single cycle. The default depth is small (64 words). Each word is 36 bits wide, split into four 9-bit byte lanes. Every input is captured on the rising clock edge.

A transfer starts on one of two address strobes:
- The processor-side strobe always begins a read.
- The controller-side strobe begins a read or a write, depending on the write controls sampled in that same cycle.

After the start, an internal 2-bit counter walks through four word locations inside one aligned group of four. It steps only when the advance input is high. The order is linear or interleaved, chosen by a mode input sampled with the strobe.

Writes can cover every lane through a global write. They can also cover a chosen subset of lanes through a byte-write enable plus per-lane strobes. Read data passes through an address register and then an output register. An output enable gates what appears at the read port.

Top module: `burst_sram`

## Requirements
- R1: While reset is low and after it is released, `rvalid` is 0 and `rdata` is zero; no burst is active, so the advance input alone causes no read until a strobe starts one.
- R2: When `start_p` is high and the device is selected, the address is loaded and the cycle is a read, even if `gw` or `bwe` with lane strobes are asserted; memory is unchanged. If both strobes are high, `start_p` wins.
- R3: When `start_c` is high (and `start_p` low) with the device selected, the address is loaded and the write controls act in that same cycle; with no lane selected the cycle is a read.
- R4: In a cycle with no strobe during an active burst, `adv`=1 steps the 2-bit counter, `adv`=0 repeats the current address, and address bits above bit 1 stay those of the start address. Write controls also apply in these cycles.
- R5: With `mode_il`=0 at the strobe, the k-th access (k=0..3) uses low offset (start + k) mod 4.
- R6: With `mode_il`=1 at the strobe, the k-th access uses low offset start XOR k.
- R7: With `gw`=0 and `bwe`=1, only lanes whose `bw[i]` is 1 are written; lane i is `wdata[9i+8:9i]`; other lanes keep their contents. With `gw`=0 and `bwe`=0 nothing is written.
- R8: With `gw`=1 all four lanes are written, whatever `bwe` and `bw` are.
- R9: The device is selected only when `ce_a`=1, `ce_b`=1 and `ce_c_n`=0. A strobe while not selected ends any burst at once: that cycle neither reads nor writes, and no further cycle does until a selected strobe.
- R10: Data for a read cycle appears on `rdata`, with `rvalid`=1, after the second rising edge counted from the edge that samples that cycle's inputs; each read cycle yields one valid cycle.
- R11: While `oe`=0, `rdata` is zero and `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_a | input | 1 | Chip enable, active high |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| start_p | input | 1 | Processor-side burst start; always a read |
| start_c | input | 1 | Controller-side burst start; honours write controls |
| adv | input | 1 | Step the burst counter in continuation cycles |
| mode_il | input | 1 | Burst order at start: 0 linear, 1 interleaved |
| gw | input | 1 | Global write of all lanes |
| bwe | input | 1 | Byte-write enable |
| bw | input | LANES | Per-lane write strobes |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| oe | input | 1 | Output enable |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The assertions assume that every input is known and steady at the sampling edge. They also assume that a word is written before it is read, because the storage has no reset. The bench therefore drives all inputs at the falling edge and fills every word through controller-strobe writes before any read.

The stepping checks assume that the counter moves only inside an active burst. The bench can only start a burst with a selected strobe and end it with an unselected one.

The read sweeps cover both orders and all four start offsets. Each sweep starts in the top groups, so a carry out of the low two bits would be visible.

// File: rtl/burst_sram_pkg.sv
// Package: shared types and the burst-order arithmetic for the burst SRAM.
// Assumes bursts are four words long (2-bit counter).
package burst_sram_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Low two address bits for the step-th access of a burst that began at start.
    function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                                input logic [1:0] step,
                                                input burst_order_e ord);
        return (ord == ORD_INTERLEAVE) ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/burst_addr_gen.sv
// Burst address generator.
// It loads a start address and order on `load`. On `step_en` it advances a
// 2-bit counter. It presents the address used in the current cycle
// combinationally.
// Assumes step_en is only raised while a burst is active and never with load.
module burst_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  burst_order_e      mode_in,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int UPPER_W = ADDR_W - 2;

    logic [UPPER_W-1:0] upper_q;
    logic [1:0]         start_q;
    logic [1:0]         cnt_q;
    logic [1:0]         cnt_use;
    burst_order_e       ord_q;

    // Count value in force for this cycle, including a step taken now.
    always_comb cnt_use = cnt_q + {1'b0, step_en};

    // Address of this cycle: a fresh start address or the burst position.
    always_comb
        eff_addr = load ? addr_in : {upper_q, burst_offset(start_q, cnt_use, ord_q)};

    // Burst state: capture the start on load, advance the counter on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            ord_q   <= ORD_LINEAR;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:2];
            start_q <= addr_in[1:0];
            cnt_q   <= '0;
            ord_q   <= mode_in;
        end else if (step_en) begin
            cnt_q <= cnt_use;
        end
    end

    // R4: upper address bits do not move between two cycles without a load
    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (load || eff_addr[ADDR_W-1:2] == $past(eff_addr[ADDR_W-1:2])));

    // R5: a linear step moves the low offset by one, modulo four
    a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && ord_q == ORD_LINEAR)
            |-> eff_addr[1:0] == $past(eff_addr[1:0]) + 2'd1);

    // R6: an interleaved step always flips the lowest offset bit
    a_r6_interleave_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && ord_q == ORD_INTERLEAVE)
            |-> eff_addr[0] != $past(eff_addr[0]));

endmodule

// File: rtl/lane_write_ctl.sv
// Write lane selection.
// A global write selects all lanes. Otherwise the byte-write enable passes
// the per-lane strobes. `allow` gates everything off in cycles that may not write.
// Assumes nothing about the encoding of bw beyond one bit per lane.
module lane_write_ctl #(
    parameter int LANES = 4
) (
    input  logic             allow,
    input  logic             gw,
    input  logic             bwe,
    input  logic [LANES-1:0] bw,
    output logic [LANES-1:0] lanes
);
    // Lane mask for this cycle, with global write taking precedence.
    always_comb begin
        if (!allow)   lanes = '0;
        else if (gw)  lanes = '1;
        else if (bwe) lanes = bw;
        else          lanes = '0;
    end
endmodule

// File: rtl/sram_array.sv
// Byte-lane storage.
// Each lane is its own array with a per-lane write enable. The read port is
// registered, so data appears one edge after rd_en/raddr are presented.
// Assumes no reset of the contents; words must be written before being read.
module sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane's slice of the write data when its strobe is set.
        always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        // Output register for this lane, loaded on a read.
        always_ff @(posedge clk) begin
            if (rd_en) rdata[g*LANE_W +: LANE_W] <= mem[raddr];
        end
    end
endmodule

// File: rtl/burst_sram.sv
// Pipelined burst SRAM top.
// It decodes the chip select and the two start strobes. It runs the burst
// address generator and the write lane control. The read goes through an
// address stage and an output stage.
// Assumes synchronous inputs that are stable around the rising edge.
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_a,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic                    start_p,
    input  logic                    start_c,
    input  logic                    adv,
    input  logic                    mode_il,
    input  logic                    gw,
    input  logic                    bwe,
    input  logic [LANES-1:0]        bw,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    localparam int DATA_W = LANES * LANE_W;

    logic              sel, strobe, load, desel, live, allow_wr, step_en;
    logic              is_write, is_read;
    logic              active_q, rd_q, valid_q;
    logic [LANES-1:0]  wr_lanes;
    logic [ADDR_W-1:0] eff_addr, addr_q;
    logic [DATA_W-1:0] arr_q;

    // Cycle decode: selection, burst start or end, and whether this cycle acts.
    always_comb begin
        sel      = ce_a & ce_b & ~ce_c_n;
        strobe   = start_p | start_c;
        load     = strobe & sel;
        desel    = strobe & ~sel;
        live     = load | (active_q & ~strobe);
        allow_wr = live & ~(start_p & sel);
        step_en  = active_q & ~strobe & adv;
        is_write = |wr_lanes;
        is_read  = live & ~is_write;
    end

    burst_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step_en (step_en),
        .addr_in (addr),
        .mode_in (burst_order_e'(mode_il)),
        .eff_addr(eff_addr)
    );

    lane_write_ctl #(.LANES(LANES)) i_lanes (
        .allow(allow_wr),
        .gw   (gw),
        .bwe  (bwe),
        .bw   (bw),
        .lanes(wr_lanes)
    );

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
        .clk  (clk),
        .we   (wr_lanes),
        .waddr(eff_addr),
        .wdata(wdata),
        .rd_en(rd_q),
        .raddr(addr_q),
        .rdata(arr_q)
    );

    // Burst activity: set by a selected strobe, cleared by an unselected one.
    always_ff @(posedge clk) begin
        if (!rst_n)     active_q <= 1'b0;
        else if (load)  active_q <= 1'b1;
        else if (desel) active_q <= 1'b0;
    end

    // Read pipeline: address stage, then a valid flag beside the output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            addr_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            rd_q    <= is_read;
            addr_q  <= eff_addr;
            valid_q <= rd_q;
        end
    end

    // Output gating by data-valid and output enable.
    always_comb begin
        rvalid = valid_q & oe;
        rdata  = rvalid ? arr_q : '0;
    end

    // R2: a selected processor-side start is always a read
    a_r2_proc_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p && sel) |=> rd_q);

    // R9: an unselected strobe leaves no read in the pipeline and no burst
    a_r9_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !sel) |=> (!rd_q && !active_q));

    // R8: a permitted global write drives every lane
    a_r8_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (gw && live && !(start_p && sel)) |-> wr_lanes == '1);

    // R11: output enable low silences the read port
    a_r11_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (rdata == '0 && !rvalid));

    // R10: valid data at the port follows a read cycle two edges earlier
    a_r10_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && oe) |=> ##1 (rvalid || !oe));

endmodule

// File: tb/test_burst_sram.sv
`timescale 1ns/1ps
// Bench: near-exhaustive sweeps over the default 64 x 36 configuration.
// Expected values come from a bench-side memory model and burst arithmetic.
module test_burst_sram;
    localparam int AW = 6;
    localparam int LANES = 4;
    localparam int LW = 9;
    localparam int DW = LANES * LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_a = 1'b1, ce_b = 1'b1, ce_c_n = 1'b0;
    logic start_p = 1'b0, start_c = 1'b0, adv = 1'b0, mode_il = 1'b0;
    logic gw = 1'b0, bwe = 1'b0, oe = 1'b1;
    logic [LANES-1:0] bw = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rvalid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [DW-1:0] mdl [64];

    always #10 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW)) i_burst_sram (
        .clk(clk), .rst_n(rst_n), .ce_a(ce_a), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .start_p(start_p), .start_c(start_c), .adv(adv), .mode_il(mode_il),
        .gw(gw), .bwe(bwe), .bw(bw), .addr(addr), .wdata(wdata), .oe(oe),
        .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [DW-1:0] pat(input int a);
        logic [DW-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*LW +: LW] = LW'((a * 11 + i * 37 + 5) % 512);
        return r;
    endfunction

    function automatic int offs(input int s, input int k, input bit il);
        return il ? (s ^ k) : ((s + k) % 4);
    endfunction

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle;
        start_p = 1'b0; start_c = 1'b0; adv = 1'b0; gw = 1'b0; bwe = 1'b0; bw = '0;
        ce_a = 1'b1; ce_b = 1'b1; ce_c_n = 1'b0; oe = 1'b1;
    endtask

    task automatic deselect;
        idle; start_c = 1'b1; ce_a = 1'b0;
        tick;
        idle;
    endtask

    task automatic write_word(input int a, input logic [DW-1:0] d, input logic g,
                              input logic b, input logic [LANES-1:0] l);
        idle; start_c = 1'b1; addr = AW'(a); wdata = d; gw = g; bwe = b; bw = l;
        tick;
        if (g) mdl[a] = d;
        else if (b) begin
            for (int i = 0; i < LANES; i++)
                if (l[i]) mdl[a][i*LW +: LW] = d[i*LW +: LW];
        end
        idle;
    endtask

    task automatic read_word(input string req, input int a);
        idle; start_p = 1'b1; addr = AW'(a);
        tick;
        deselect;
        check(req, rdata, mdl[a]);
        check(req, DW'(rvalid), DW'(1));
        tick;
    endtask

    initial begin
        idle;
        rst_n = 1'b0;
        repeat (3) tick;
        check("R1 rvalid in reset", DW'(rvalid), DW'(0));
        check("R1 rdata in reset", rdata, '0);
        rst_n = 1'b1;
        adv = 1'b1;
        tick; tick; tick;
        check("R1 no burst after reset", DW'(rvalid), DW'(0));
        idle;

        // R3: fill every word with controller-side global writes
        for (int a = 0; a < 64; a++) write_word(a, pat(a), 1'b1, 1'b0, '0);
        deselect;
        tick;
        check("R3 no read during writes", DW'(rvalid), DW'(0));
        read_word("R3 word 0", 0);
        read_word("R3 word 63", 63);
        read_word("R3 word 21", 21);

        // R5/R6/R4/R10: every start offset in both orders
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                int base;
                base = 15 - s * 3 - m;
                idle; start_p = 1'b1; addr = AW'(base * 4 + s); mode_il = m[0];
                tick;
                for (int k = 1; k < 4; k++) begin
                    idle; adv = 1'b1;
                    tick;
                    check(m ? "R6 interleaved R10" : "R5 linear R10", rdata,
                          mdl[base * 4 + offs(s, k - 1, m[0])]);
                    check("R10 valid", DW'(rvalid), DW'(1));
                end
                deselect;
                check(m ? "R6 last R4" : "R5 last R4", rdata, mdl[base * 4 + offs(s, 3, m[0])]);
                tick;
                check("R9 idle after deselect", DW'(rvalid), DW'(0));
            end
        end
        mode_il = 1'b0;

        // R4: adv low holds the address, then a step resumes
        idle; start_p = 1'b1; addr = AW'(40 + 2);
        tick;
        idle; adv = 1'b0;
        tick;
        check("R4 first", rdata, mdl[42]);
        idle; adv = 1'b1;
        tick;
        check("R4 hold repeats", rdata, mdl[42]);
        deselect;
        check("R4 step after hold", rdata, mdl[43]);
        tick;

        // R2: processor-side start ignores write controls
        idle; start_p = 1'b1; addr = AW'(9); gw = 1'b1; bwe = 1'b1; bw = '1; wdata = ~mdl[9];
        tick;
        deselect;
        check("R2 reads old data", rdata, mdl[9]);
        tick;
        read_word("R2 memory unchanged", 9);

        // R2: both strobes together still give a read
        idle; start_p = 1'b1; start_c = 1'b1; addr = AW'(10); gw = 1'b1; wdata = ~mdl[10];
        tick;
        deselect;
        check("R2 both strobes read", rdata, mdl[10]);
        tick;
        read_word("R2 both strobes unchanged", 10);

        // R7: partial byte write, then a write with bwe low
        write_word(30, 36'hF_0F0F_0F0F, 1'b0, 1'b1, 4'b0101);
        deselect; tick;
        read_word("R7 lanes 0 and 2 only", 30);
        write_word(31, ~mdl[31], 1'b0, 1'b0, 4'b1111);
        deselect;
        check("R7 bwe low reads instead", rdata, mdl[31]);
        tick;
        read_word("R7 bwe low unchanged", 31);

        // R8: global write beats a single lane strobe
        write_word(32, 36'h1_2345_6789, 1'b1, 1'b1, 4'b0001);
        deselect; tick;
        read_word("R8 all lanes written", 32);

        // R4: write in a continuation cycle lands on the stepped address
        idle; start_p = 1'b1; addr = AW'(44);
        tick;
        idle; adv = 1'b1; gw = 1'b1; wdata = 36'hA_BCDE_F012;
        tick;
        mdl[45] = 36'hA_BCDE_F012;
        deselect; tick;
        read_word("R4 continuation write", 45);

        // R9: each enable inactive blocks a write and any read
        for (int e = 0; e < 3; e++) begin
            idle; start_c = 1'b1; gw = 1'b1; addr = AW'(50 + e); wdata = ~mdl[50 + e];
            if (e == 0) ce_a = 1'b0;
            else if (e == 1) ce_b = 1'b0;
            else ce_c_n = 1'b1;
            tick;
            idle;
            tick;
            check("R9 unselected no read", DW'(rvalid), DW'(0));
            read_word("R9 unselected no write", 50 + e);
        end

        // R11: output enable low hides a valid read
        idle; start_p = 1'b1; addr = AW'(12);
        tick;
        idle; oe = 1'b0;
        tick;
        check("R11 rdata gated", rdata, '0);
        check("R11 rvalid gated", DW'(rvalid), DW'(0));
        deselect;
        check("R11 data returns with oe", rdata, mdl[12]);
        tick;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule